// File: doc/BRIEF.md
# Real-Time Clock Register Block with Interrupt Groups

This block is the register side of a real-time clock. It keeps a 32-bit seconds count that advances on a one-pulse-per-second input. It also counts the pulses themselves and holds an alarm, a calibration value, a control word and a scratch word. Software reaches all of these over a 32-bit register bus. The bus accepts whole, aligned, little-endian words only.

Interrupts come in two groups. The event group has two causes: bit 0 is the alarm match and bit 1 is the seconds pulse. The address-error group has one cause, a bad bus access. Each group has a status register that is cleared by writing ones. Its mask cannot be written directly. The mask changes only through an enable command, which clears mask bits, and a disable command, which sets them. Both command registers read back as zero. Each group drives its own level interrupt pin.

The bus side uses a request channel and a response channel, each with valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or when the waiting response is being taken in the same cycle. The response, carrying read data or zero for a write, appears on the edge that accepts the request. Under back-pressure it holds until `rsp_ready` is high.

Top module: `rtc_regfile`

## Requirements
- R1: `irq_event` is high exactly when some event status bit is set and its mask bit is clear. It reflects a status, enable or disable write from the edge that accepts that write.
- R2: Event status sits at byte offset 0x1C. Bit 0 is set when an armed alarm matches and bit 1 is set on each seconds pulse. Writing a 1 clears a bit, unless a new event sets it on the same edge.
- R3: The event mask at offset 0x20 resets to 0x3 and ignores bus writes.
- R4: A write to offset 0x24 clears the event mask bits that are 1 in the data. A write to offset 0x28 sets them. Both offsets read as zero.
- R5: The address-error group works the same way with one bit: status at 0x2C (write one to clear), a mask at 0x30 that resets to 1, enable at 0x34, disable at 0x38, and its own pin `irq_addr_err`.
- R6: The seconds count increments on each cycle with `pps` high. A write to offset 0x00 loads it on the accepting edge and wins over a pulse on that edge.
- R7: Offsets 0x04 and 0x10 both return the live seconds count and ignore writes. Offset 0x00 reads as zero.
- R8: Offset 0x0C returns the low 21 bits of the last write to offset 0x08, and offset 0x08 reads as zero. Offset 0x14 returns the number of pulses since reset, modulo 2^16. Writes to 0x0C and 0x14 are ignored.
- R9: The control word at offset 0x3C resets to 0x01000000, and bits set in 0x70FFFFFE always read as zero. The scratch word at offset 0x40 is fully read/write and resets to zero.
- R10: An access is in error if its byte enables are not 4'hF, its address is not word aligned, or its offset is above 0x40. Such an access changes no register, returns zero and sets address-error status.
- R11: A write to the alarm at offset 0x18 stores the value and arms it. While armed, a seconds count equal to the alarm sets event bit 0 one edge later and disarms it.
- R12: `req_ready` equals `!rsp_valid || rsp_ready`. A response is presented on the accepting edge, holds its data stable while stalled, and write responses carry zero.
- R13: After reset both interrupt pins are low, no response is pending and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps | input | 1 | One-cycle pulse per elapsed second |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; must be 4'hF |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_rdata | output | 32 | Read data, zero for writes and bad accesses |
| irq_event | output | 1 | Level interrupt for the event group |
| irq_addr_err | output | 1 | Level interrupt for the address-error group |

## Verification
Register and mask changes take effect on the edge that accepts a write. The interrupt pins follow on that same edge, since they are combinational from registers. A read response appears on the accepting edge and carries the state from before that edge. An alarm match lands in status one edge after the seconds count reaches the alarm value. The bench drives on falling edges and samples pins only at the falling edge after a task has completed its response. It waits at least one extra edge after any pulse before reading alarm status, so every value is read after the register stage that produces it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int SEC_W  = 32;
  localparam int CAL_W  = 21;
  localparam int TICK_W = 16;
  localparam int EV_W   = 2;
  localparam int AE_W   = 1;

  // Word indices (byte offset / 4); the bench and software rely on these.
  localparam int unsigned IDX_SET_WR  = 0;
  localparam int unsigned IDX_SET_RD  = 1;
  localparam int unsigned IDX_CAL_WR  = 2;
  localparam int unsigned IDX_CAL_RD  = 3;
  localparam int unsigned IDX_NOW     = 4;
  localparam int unsigned IDX_TICKS   = 5;
  localparam int unsigned IDX_ALARM   = 6;
  localparam int unsigned IDX_EV_STAT = 7;
  localparam int unsigned IDX_EV_MASK = 8;
  localparam int unsigned IDX_EV_EN   = 9;
  localparam int unsigned IDX_EV_DIS  = 10;
  localparam int unsigned IDX_AE_STAT = 11;
  localparam int unsigned IDX_AE_MASK = 12;
  localparam int unsigned IDX_AE_EN   = 13;
  localparam int unsigned IDX_AE_DIS  = 14;
  localparam int unsigned IDX_CTRL    = 15;
  localparam int unsigned IDX_SCRATCH = 16;
  localparam int unsigned IDX_LAST    = IDX_SCRATCH;

  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0100_0000;
  localparam logic [DATA_W-1:0] CTRL_RSVD  = 32'h70FF_FFFE;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = ~CTRL_RSVD;
endpackage

// File: rtl/rtc_bus_port.sv
module rtc_bus_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          accept,
  input  logic [DW-1:0] rd_next,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = vld_q;
  assign rsp_rdata = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      dat_q <= rd_next;
    end else if (rsp_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_time_base.sv
module rtc_time_base #(
  parameter int SW = 32,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps,
  input  logic          load_en,
  input  logic [SW-1:0] load_val,
  input  logic          alarm_wr,
  input  logic [SW-1:0] alarm_val,
  output logic [SW-1:0] seconds,
  output logic [TW-1:0] ticks,
  output logic [SW-1:0] alarm,
  output logic          alarm_hit
);
  logic [SW-1:0] sec_q;
  logic [TW-1:0] tick_q;
  logic [SW-1:0] alarm_q;
  logic          armed_q;

  assign alarm_hit = armed_q && (sec_q == alarm_q);
  assign seconds   = sec_q;
  assign ticks     = tick_q;
  assign alarm     = alarm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      tick_q <= '0;
    end else begin
      if (load_en)  sec_q <= load_val;
      else if (pps) sec_q <= sec_q + 1'b1;
      if (pps) tick_q <= tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
      armed_q <= 1'b0;
    end else if (alarm_wr) begin
      alarm_q <= alarm_val;
      armed_q <= 1'b1;
    end else if (alarm_hit) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_irq_group.sv
module rtc_irq_group #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         w1c_en,
  input  logic         en_cmd,
  input  logic         dis_cmd,
  input  logic [W-1:0] wr_bits,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] stat_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] clr_vec;

  assign clr_vec = w1c_en ? wr_bits : '0;
  assign status  = stat_q;
  assign mask    = mask_q;
  assign irq     = |(stat_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      if (en_cmd)       mask_q <= mask_q & ~wr_bits;
      else if (dis_cmd) mask_q <= mask_q | wr_bits;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              irq_event,
  output logic              irq_addr_err
);
  localparam int IDX_W = ADDR_W - 2;

  logic              accept;
  logic [IDX_W-1:0]  idx;
  logic              mapped, good, wr;
  logic [DATA_W-1:0] rd_next, rd_mux;

  logic [SEC_W-1:0]  seconds, alarm;
  logic [TICK_W-1:0] ticks;
  logic              alarm_hit;
  logic [EV_W-1:0]   ev_status, ev_mask;
  logic [AE_W-1:0]   ae_status, ae_mask;
  logic [CAL_W-1:0]  cal_q;
  logic [DATA_W-1:0] ctrl_q, scratch_q;

  assign idx    = req_addr[ADDR_W-1:2];
  assign mapped = int'(idx) <= int'(IDX_LAST);
  assign good   = (req_be == 4'hF) && (req_addr[1:0] == 2'b00) && mapped;
  assign wr     = accept && req_write && good;

  function automatic logic hit(input logic [IDX_W-1:0] i, input int unsigned n);
    return int'(i) == int'(n);
  endfunction

  rtc_bus_port #(.DW(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .rd_next(rd_next), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  rtc_time_base #(.SW(SEC_W), .TW(TICK_W)) u_time (
    .clk(clk), .rst_n(rst_n), .pps(pps),
    .load_en(wr && hit(idx, IDX_SET_WR)), .load_val(req_wdata),
    .alarm_wr(wr && hit(idx, IDX_ALARM)), .alarm_val(req_wdata),
    .seconds(seconds), .ticks(ticks), .alarm(alarm), .alarm_hit(alarm_hit)
  );

  rtc_irq_group #(.W(EV_W)) u_ev (
    .clk(clk), .rst_n(rst_n),
    .set_vec({pps, alarm_hit}),
    .w1c_en(wr && hit(idx, IDX_EV_STAT)),
    .en_cmd(wr && hit(idx, IDX_EV_EN)),
    .dis_cmd(wr && hit(idx, IDX_EV_DIS)),
    .wr_bits(req_wdata[EV_W-1:0]),
    .status(ev_status), .mask(ev_mask), .irq(irq_event)
  );

  rtc_irq_group #(.W(AE_W)) u_ae (
    .clk(clk), .rst_n(rst_n),
    .set_vec(accept && !good),
    .w1c_en(wr && hit(idx, IDX_AE_STAT)),
    .en_cmd(wr && hit(idx, IDX_AE_EN)),
    .dis_cmd(wr && hit(idx, IDX_AE_DIS)),
    .wr_bits(req_wdata[AE_W-1:0]),
    .status(ae_status), .mask(ae_mask), .irq(irq_addr_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q     <= '0;
      ctrl_q    <= CTRL_RESET;
      scratch_q <= '0;
    end else if (wr) begin
      if (hit(idx, IDX_CAL_WR))  cal_q     <= req_wdata[CAL_W-1:0];
      if (hit(idx, IDX_CTRL))    ctrl_q    <= req_wdata & CTRL_KEEP;
      if (hit(idx, IDX_SCRATCH)) scratch_q <= req_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(idx, IDX_SET_RD) || hit(idx, IDX_NOW)) rd_mux = seconds;
    if (hit(idx, IDX_CAL_RD))  rd_mux = DATA_W'(cal_q);
    if (hit(idx, IDX_TICKS))   rd_mux = DATA_W'(ticks);
    if (hit(idx, IDX_ALARM))   rd_mux = alarm;
    if (hit(idx, IDX_EV_STAT)) rd_mux = DATA_W'(ev_status);
    if (hit(idx, IDX_EV_MASK)) rd_mux = DATA_W'(ev_mask);
    if (hit(idx, IDX_AE_STAT)) rd_mux = DATA_W'(ae_status);
    if (hit(idx, IDX_AE_MASK)) rd_mux = DATA_W'(ae_mask);
    if (hit(idx, IDX_CTRL))    rd_mux = ctrl_q;
    if (hit(idx, IDX_SCRATCH)) rd_mux = scratch_q;
  end

  assign rd_next = (req_write || !good) ? '0 : rd_mux;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pps,
  input logic              wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [31:0]       seconds,
  input logic [1:0]        ev_status,
  input logic [1:0]        ev_mask,
  input logic [0:0]        ae_mask,
  input logic              irq_event,
  input logic              irq_addr_err
);
  logic [ADDR_W-3:0] w_idx;
  logic load, en_w, dis_w;
  assign w_idx = req_addr[ADDR_W-1:2];
  assign load  = wr && (int'(w_idx) == 0);
  assign en_w  = wr && (int'(w_idx) == 9);
  assign dis_w = wr && (int'(w_idx) == 10);

  p_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mask == 2'b11) |-> !irq_event);
  p_tick_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pps |=> ev_status[1]);
  p_en_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |=> ((ev_mask & $past(req_wdata[1:0])) == 2'b00));
  p_dis_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dis_w |=> ((ev_mask & $past(req_wdata[1:0])) == $past(req_wdata[1:0])));
  p_ae_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ae_mask[0] |-> !irq_addr_err);
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pps) |=> (seconds == $past(seconds) + 32'd1));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (seconds == $past(req_wdata)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pps) |=> $stable(seconds));
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind rtc_regfile rtc_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pps(pps), .wr(wr), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .seconds(seconds), .ev_status(ev_status),
  .ev_mask(ev_mask), .ae_mask(ae_mask), .irq_event(irq_event),
  .irq_addr_err(irq_addr_err)
);

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;
  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic irq_event, irq_addr_err;
  logic pps_with_req = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_sec = 0, exp_safe = 0, exp_ctrl = 32'h0100_0000;
  logic [15:0] exp_tick = 0;
  logic [1:0]  exp_evs = 0, exp_evm = 2'b11;

  always #2 clk = ~clk;

  rtc_regfile u_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .pps(pps), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq_event(irq_event),
    .irq_addr_err(irq_addr_err)
  );

  function automatic logic exp_irq(input logic [1:0] s, input logic [1:0] m);
    return |(s & ~m);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic xfer(input bit w, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    pps = pps_with_req;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; pps = 1'b0;
    rsp_ready = ($urandom % 4) != 0;
    while (!(rsp_valid && rsp_ready)) begin
      @(negedge clk);
      rsp_ready = ($urandom % 4) != 0;
    end
    r = rsp_rdata;
    @(posedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, 4'hF, d, r);
    check("R12 write response", r, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    xfer(1'b0, a, 4'hF, 32'h0, r);
  endtask

  task automatic tick();
    @(negedge clk); pps = 1'b1;
    @(negedge clk); pps = 1'b0;
    exp_sec++; exp_tick++; exp_evs[1] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %08h expected %08h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 irq_event", {31'b0, irq_event}, 0);
    check("R13 irq_addr_err", {31'b0, irq_addr_err}, 0);
    check("R13 rsp_valid", {31'b0, rsp_valid}, 0);
    check("R13 req_ready", {31'b0, req_ready}, 1);
    rd(8'h20, r); check("R3 mask reset", r, 32'h3);
    rd(8'h30, r); check("R5 ae mask reset", r, 32'h1);
    rd(8'h3C, r); check("R9 ctrl reset", r, 32'h0100_0000);
    rd(8'h10, r); check("R7 time reset", r, 0);
    rd(8'h14, r); check("R8 ticks reset", r, 0);

    // R6 count and load, load wins over pulse
    tick(); tick();
    rd(8'h10, r); check("R6 count after two pulses", r, exp_sec);
    rd(8'h04, r); check("R7 set-time readback", r, exp_sec);
    pps_with_req = 1'b1;
    wr(8'h00, 32'd500);
    pps_with_req = 1'b0;
    exp_sec = 500; exp_tick++; exp_evs[1] = 1'b1;
    rd(8'h10, r); check("R6 load wins over pulse", r, 32'd500);
    rd(8'h14, r); check("R8 tick count", r, {16'h0, exp_tick});
    rd(8'h00, r); check("R7 set-time write reads zero", r, 0);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, r); check("R7 write to time ignored", r, 32'd500);

    // R8 calibration
    wr(8'h08, 32'hFFF1_2345);
    rd(8'h0C, r); check("R8 cal 21 bits", r, 32'h0011_2345);
    rd(8'h08, r); check("R8 cal write reads zero", r, 0);
    wr(8'h0C, 32'h0);
    rd(8'h0C, r); check("R8 cal readback ignores write", r, 32'h0011_2345);

    // R3/R4 masks
    wr(8'h20, 32'h0);
    rd(8'h20, r); check("R3 mask read-only", r, 32'h3);
    check("R1 masked no irq", {31'b0, irq_event}, 0);
    wr(8'h24, 32'h2); exp_evm = 2'b01;
    @(negedge clk);
    check("R1 irq after enable", {31'b0, irq_event}, 1);
    rd(8'h24, r); check("R4 enable reads zero", r, 0);
    rd(8'h28, r); check("R4 disable reads zero", r, 0);
    wr(8'h1C, 32'h2); exp_evs[1] = 1'b0;
    @(negedge clk);
    check("R2 w1c clears irq", {31'b0, irq_event}, 0);

    // R11 alarm
    wr(8'h24, 32'h1); exp_evm = 2'b00;
    wr(8'h00, 32'd100); exp_sec = 100;
    wr(8'h18, 32'd102);
    tick();
    rd(8'h1C, r); check("R11 no early alarm", r, {30'b0, exp_evs});
    tick(); exp_evs[0] = 1'b1;
    rd(8'h1C, r); check("R11 alarm hit", r, 32'h3);
    wr(8'h1C, 32'h3); exp_evs = 0;
    rd(8'h1C, r); check("R2 w1c both", r, 0);
    tick();
    rd(8'h1C, r); check("R11 disarmed after hit", r, 32'h2);
    wr(8'h28, 32'h3); exp_evm = 2'b11;
    rd(8'h20, r); check("R4 disable sets mask", r, 32'h3);

    // R5/R10 address error
    rd(8'h44, r); check("R10 unmapped reads zero", r, 0);
    rd(8'h2C, r); check("R10 unmapped sets error", r, 1);
    check("R5 masked ae irq", {31'b0, irq_addr_err}, 0);
    wr(8'h34, 32'h1);
    @(negedge clk);
    check("R5 ae irq after enable", {31'b0, irq_addr_err}, 1);
    wr(8'h2C, 32'h1);
    @(negedge clk);
    check("R5 ae w1c", {31'b0, irq_addr_err}, 0);
    wr(8'h40, 32'h1111_2222); exp_safe = 32'h1111_2222;
    xfer(1'b1, 8'h40, 4'h3, 32'hAAAA_BBBB, r);
    rd(8'h40, r); check("R10 partial write dropped", r, exp_safe);
    check("R10 partial sets ae irq", {31'b0, irq_addr_err}, 1);
    wr(8'h2C, 32'h1);
    xfer(1'b1, 8'h42, 4'hF, 32'h0, r);
    rd(8'h2C, r); check("R10 unaligned sets error", r, 1);
    wr(8'h38, 32'h1);
    wr(8'h2C, 32'h1);
    check("R5 disable masks", {31'b0, irq_addr_err}, 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom % 10;
      d = $urandom;
      case (op)
        0: tick();
        1: begin wr(8'h00, d); exp_sec = d; end
        2: begin rd((i % 2) ? 8'h10 : 8'h04, r); check("R7 live time", r, exp_sec); end
        3: begin wr(8'h24, d); exp_evm &= ~d[1:0]; end
        4: begin wr(8'h28, d); exp_evm |= d[1:0]; end
        5: begin
             rd(8'h1C, r); check("R2 status", r, {30'b0, exp_evs});
             rd(8'h20, r); check("R4 mask", r, {30'b0, exp_evm});
             check("R1 irq level", {31'b0, irq_event}, {31'b0, exp_irq(exp_evs, exp_evm)});
           end
        6: begin wr(8'h1C, d); exp_evs &= ~d[1:0]; end
        7: begin wr(8'h40, d); rd(8'h40, r); check("R9 scratch", r, d); end
        8: begin wr(8'h3C, d); exp_ctrl = d & ~32'h70FF_FFFE;
             rd(8'h3C, r); check("R9 ctrl reserved", r, exp_ctrl); end
        default: begin
             wr(8'h14, d); rd(8'h14, r); check("R8 ticks read-only", r, {16'h0, exp_tick});
           end
      endcase
    end
    finish_run();
  end
endmodule